// File: doc/BRIEF.md
# Display configuration commit controller

This block decides when display settings written by software become the settings the display pipeline actually uses. Software writes a small bank of configuration words through a simple register write port. The block holds them apart from the active copy that drives the pipeline, and copies them across only at moments that cannot tear a frame.

Two interface modes are supported. In continuous video mode the written words form a pending bank. An update request copies that bank to the active bank at the next frame boundary and then reports an update-done event. A stop request ends output at the close of the current frame and reports done.

In tear-effect-driven command mode there is no shadowing. The bank is sampled once, on the rising edge of the run bit. The frame then waits for a tear-effect pulse from the selected source and runs until the frame ends. At that point run clears by itself and done is reported. A new run edge is accepted only once the block has returned to idle.

Top module: `disp_commit_ctrl`

## Requirements
- R1: After a synchronous reset, the active configuration is all zero, the control bits read 0, the mode reads video (0), scanning is low and both event outputs are low.
- R2: A write to a bank word (address 4+i sets word i, which appears on active_cfg_o bits [i*DATA_W +: DATA_W]) never changes active_cfg_o by itself. Only a run edge or a video-mode update commit copies the bank into the active configuration.
- R3: Writing the control word (address 0) with bit 0 (run) set while idle copies the whole bank to active_cfg_o at that clock edge and sets control bit 0. In video mode, scan_active_o is high from that edge on.
- R4: In video mode while scanning, writing control bit 2 (update) sets it. At the next frame_end_i pulse, the bank is copied to the active configuration, bit 2 clears in that same edge, and evt_upd_o is high for exactly that following cycle.
- R5: In video mode while scanning, writing control bit 1 (stop) sets it, but scanning continues until frame_end_i. At that boundary, scan_active_o, run and stop all clear and evt_done_o pulses for one cycle.
- R6: Writes of the stop or update bits while the block is idle are ignored, and the control bits stay 0.
- R7: In command mode (mode word at address 1, bit 0 = 1) with tear-effect enable set (interface control word at address 2, bit 8), a run edge latches the bank and arms the block. Scanning starts in the cycle after a rising edge on the selected tear-effect input.
- R8: Bit 10 of the interface control word selects the tear-effect source: 1 selects te_pad_i and 0 selects te_int_i. A pulse on the unselected input has no effect. With bit 8 clear, scanning starts at the run edge itself.
- R9: In command mode, frame_end_i during scanning ends the frame: scan_active_o and run clear, and evt_done_o pulses for one cycle.
- R10: In command mode, run writes while armed or scanning are ignored, leaving the active configuration unchanged. The stop and update bits are never set in command mode.
- R11: Writes to the mode word are ignored while run is set.
- R12: evt_done_o and evt_upd_o are never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| frame_end_i | input | 1 | Frame boundary pulse from the timing generator |
| te_pad_i | input | 1 | Tear-effect signal from the external pad |
| te_int_i | input | 1 | Tear-effect signal from the internal source |
| active_cfg_o | output | NUM_CFG*DATA_W | Active configuration words, word i at [i*DATA_W +: DATA_W] |
| ctrl_bits_o | output | 3 | Control bits {update, stop, run} |
| cfg_mode_o | output | 1 | Interface mode in force (0 video, 1 command) |
| scan_active_o | output | 1 | Frame output in progress |
| evt_done_o | output | 1 | One-cycle pulse when output has stopped |
| evt_upd_o | output | 1 | One-cycle pulse when an update commit has happened |

## Verification
The bench loads the pending bank while a video frame is running and checks that nothing reaches the active copy until an update meets a frame boundary. A design that committed on the write itself would tear the displayed frame.

It issues stop in mid-frame and checks that output continues until the boundary. An early halt would cut a frame short.

In command mode it fires tear-effect pulses on the unselected source and sends repeated run writes during a frame. A design with a wrong source select would start the frame early. A design that accepted run edges while busy would latch a half-written bank.

Random rounds of bank writes, with and without an update request, are checked against a bench model. These rounds catch an update bit that fails to self-clear and a commit that takes the wrong bank.

// File: rtl/disp_commit_pkg.sv
package disp_commit_pkg;

    // register addresses
    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_MODE      = 1;
    localparam int ADDR_IFC       = 2;
    localparam int ADDR_BANK_BASE = 4;

    // control word bit positions
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_STOP_BIT = 1;
    localparam int CTRL_UPD_BIT  = 2;

    // interface control word bit positions
    localparam int IFC_TE_EN_BIT  = 8;
    localparam int IFC_TE_PAD_BIT = 10;

    // narrowest slice of write data that holds every control field
    localparam int CTRL_FIELD_W = IFC_TE_PAD_BIT + 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_SCAN  = 2'd2
    } seq_state_e;

    typedef enum logic {
        IF_VIDEO = 1'b0,
        IF_CMD   = 1'b1
    } if_mode_e;

    typedef struct packed {
        logic upd;
        logic stop;
        logic run;
    } ctrl_bits_t;

    typedef struct packed {
        logic te_en;
        logic te_pad;
    } te_cfg_t;

    function automatic ctrl_bits_t decode_ctrl(input logic [CTRL_FIELD_W-1:0] w);
        ctrl_bits_t c;
        c.run  = w[CTRL_RUN_BIT];
        c.stop = w[CTRL_STOP_BIT];
        c.upd  = w[CTRL_UPD_BIT];
        return c;
    endfunction

    function automatic te_cfg_t decode_ifc(input logic [CTRL_FIELD_W-1:0] w);
        te_cfg_t t;
        t.te_en  = w[IFC_TE_EN_BIT];
        t.te_pad = w[IFC_TE_PAD_BIT];
        return t;
    endfunction

endpackage

// File: rtl/dcc_cfg_bank.sv
module dcc_cfg_bank
    import disp_commit_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        load_i,
    output logic [NUM_CFG*DATA_W-1:0]   active_o
);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
        logic              sel;
        logic [DATA_W-1:0] pend_q;
        logic [DATA_W-1:0] act_q;

        assign sel = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_BANK_BASE + g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= '0;
                act_q  <= '0;
            end else begin
                if (sel) begin
                    pend_q <= wr_data_i;
                end
                if (load_i) begin
                    act_q <= pend_q;
                end
            end
        end

        assign active_o[g*DATA_W +: DATA_W] = act_q;
    end

endmodule

// File: rtl/dcc_te_select.sv
module dcc_te_select (
    input  logic clk,
    input  logic rst,
    input  logic te_pad_i,
    input  logic te_int_i,
    input  logic pad_sel_i,
    output logic te_fire_o
);

    logic pad_prev_q;
    logic int_prev_q;
    logic pad_rise;
    logic int_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_prev_q <= 1'b0;
            int_prev_q <= 1'b0;
        end else begin
            pad_prev_q <= te_pad_i;
            int_prev_q <= te_int_i;
        end
    end

    assign pad_rise  = te_pad_i & ~pad_prev_q;
    assign int_rise  = te_int_i & ~int_prev_q;
    assign te_fire_o = pad_sel_i ? pad_rise : int_rise;

endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
    import disp_commit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [CTRL_FIELD_W-1:0] wr_data_i,
    input  logic                    frame_end_i,
    input  logic                    te_fire_i,
    output logic                    load_o,
    output logic [2:0]              ctrl_o,
    output logic                    mode_o,
    output logic                    te_pad_sel_o,
    output logic                    scan_o,
    output logic                    evt_done_o,
    output logic                    evt_upd_o
);

    seq_state_e state_q, state_nx;
    if_mode_e   mode_q, mode_nx;
    ctrl_bits_t ctrl_q, ctrl_nx;
    te_cfg_t    te_q, te_nx;
    logic       done_q, done_nx;
    logic       updev_q, updev_nx;
    logic       load;

    logic       wr_ctrl, wr_mode, wr_ifc;
    ctrl_bits_t req;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
    assign wr_mode = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MODE));
    assign wr_ifc  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_IFC));
    assign req     = wr_ctrl ? decode_ctrl(wr_data_i) : '0;

    always_comb begin
        state_nx = state_q;
        mode_nx  = mode_q;
        ctrl_nx  = ctrl_q;
        te_nx    = te_q;
        done_nx  = 1'b0;
        updev_nx = 1'b0;
        load     = 1'b0;

        if (wr_ifc) begin
            te_nx = decode_ifc(wr_data_i);
        end
        if (wr_mode && !ctrl_q.run) begin
            mode_nx = if_mode_e'(wr_data_i[0]);
        end

        unique case (state_q)
            SEQ_IDLE: begin
                if (req.run) begin
                    ctrl_nx.run = 1'b1;
                    load        = 1'b1;
                    state_nx    = (mode_q == IF_CMD && te_q.te_en) ? SEQ_ARMED : SEQ_SCAN;
                end
            end
            SEQ_ARMED: begin
                if (te_fire_i) begin
                    state_nx = SEQ_SCAN;
                end
            end
            SEQ_SCAN: begin
                if (mode_q == IF_VIDEO) begin
                    if (req.stop) ctrl_nx.stop = 1'b1;
                    if (req.upd)  ctrl_nx.upd  = 1'b1;
                    if (frame_end_i) begin
                        if (ctrl_q.upd) begin
                            load        = 1'b1;
                            ctrl_nx.upd = req.upd;
                            updev_nx    = 1'b1;
                        end
                        if (ctrl_q.stop) begin
                            state_nx     = SEQ_IDLE;
                            ctrl_nx      = '0;
                            done_nx      = 1'b1;
                        end
                    end
                end else begin
                    if (frame_end_i) begin
                        state_nx    = SEQ_IDLE;
                        ctrl_nx     = '0;
                        done_nx     = 1'b1;
                    end
                end
            end
            default: begin
                state_nx = SEQ_IDLE;
                ctrl_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            mode_q  <= IF_VIDEO;
            ctrl_q  <= '0;
            te_q    <= '0;
            done_q  <= 1'b0;
            updev_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            mode_q  <= mode_nx;
            ctrl_q  <= ctrl_nx;
            te_q    <= te_nx;
            done_q  <= done_nx;
            updev_q <= updev_nx;
        end
    end

    assign load_o       = load;
    assign ctrl_o       = ctrl_q;
    assign mode_o       = mode_q;
    assign te_pad_sel_o = te_q.te_pad;
    assign scan_o       = (state_q == SEQ_SCAN);
    assign evt_done_o   = done_q;
    assign evt_upd_o    = updev_q;

endmodule

// File: rtl/disp_commit_ctrl.sv
module disp_commit_ctrl
    import disp_commit_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic                      frame_end_i,
    input  logic                      te_pad_i,
    input  logic                      te_int_i,
    output logic [NUM_CFG*DATA_W-1:0] active_cfg_o,
    output logic [2:0]                ctrl_bits_o,
    output logic                      cfg_mode_o,
    output logic                      scan_active_o,
    output logic                      evt_done_o,
    output logic                      evt_upd_o
);

    logic load_w;
    logic te_fire_w;
    logic pad_sel_w;

    dcc_cfg_bank #(
        .NUM_CFG (NUM_CFG),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) bank_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load_w),
        .active_o  (active_cfg_o)
    );

    dcc_te_select te_i (
        .clk       (clk),
        .rst       (rst),
        .te_pad_i  (te_pad_i),
        .te_int_i  (te_int_i),
        .pad_sel_i (pad_sel_w),
        .te_fire_o (te_fire_w)
    );

    dcc_seq #(
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i[CTRL_FIELD_W-1:0]),
        .frame_end_i  (frame_end_i),
        .te_fire_i    (te_fire_w),
        .load_o       (load_w),
        .ctrl_o       (ctrl_bits_o),
        .mode_o       (cfg_mode_o),
        .te_pad_sel_o (pad_sel_w),
        .scan_o       (scan_active_o),
        .evt_done_o   (evt_done_o),
        .evt_upd_o    (evt_upd_o)
    );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst,
    input logic         frame_end_i,
    input logic [W-1:0] active_i,
    input logic [2:0]   ctrl_i,
    input logic         mode_i,
    input logic         scan_i,
    input logic         done_i,
    input logic         upd_i,
    input logic         load_i
);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !done_i);

    assert_upd_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> !upd_i);

    assert_commit_only_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_i) |-> $past(load_i));

    assert_upd_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        upd_i |-> !ctrl_i[2]);

    assert_stop_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(scan_i) |-> $past(frame_end_i));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (!scan_i && !ctrl_i[0]));

    assert_cmd_no_flags_R10: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> (ctrl_i[2:1] == 2'b00));

endmodule

bind disp_commit_ctrl dcc_checker #(.W(NUM_CFG*DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .frame_end_i (frame_end_i),
    .active_i    (active_cfg_o),
    .ctrl_i      (ctrl_bits_o),
    .mode_i      (cfg_mode_o),
    .scan_i      (scan_active_o),
    .done_i      (evt_done_o),
    .upd_i       (evt_upd_o),
    .load_i      (load_w)
);

// File: tb/disp_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module disp_commit_ctrl_tb_top;

    localparam int NUM_CFG = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int W       = NUM_CFG * DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              frame_end = 1'b0;
    logic              te_pad = 1'b0;
    logic              te_int = 1'b0;
    logic [W-1:0]      active;
    logic [2:0]        ctrl;
    logic              mode;
    logic              scan;
    logic              evt_done;
    logic              evt_upd;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [DATA_W-1:0] exp_bank [NUM_CFG];
    logic [W-1:0]      exp_active = '0;

    always #4 clk = ~clk;

    disp_commit_ctrl #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .frame_end_i(frame_end), .te_pad_i(te_pad), .te_int_i(te_int),
        .active_cfg_o(active), .ctrl_bits_o(ctrl), .cfg_mode_o(mode),
        .scan_active_o(scan), .evt_done_o(evt_done), .evt_upd_o(evt_upd));

    function automatic logic [W-1:0] pack_bank();
        logic [W-1:0] v;
        for (int i = 0; i < NUM_CFG; i++) v[i*DATA_W +: DATA_W] = exp_bank[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_bank(input int idx, input logic [DATA_W-1:0] data);
        wr(4 + idx, data);
        exp_bank[idx] = data;
    endtask

    task automatic fill_bank();
        for (int i = 0; i < NUM_CFG; i++) wr_bank(i, $urandom);
    endtask

    task automatic pulse_fe();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic pulse_pad();
        @(negedge clk); te_pad = 1'b1;
        @(negedge clk); te_pad = 1'b0;
    endtask

    task automatic pulse_int();
        @(negedge clk); te_int = 1'b1;
        @(negedge clk); te_int = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NUM_CFG; i++) exp_bank[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(active == '0, "R1 active", active, '0);
        chk({mode, scan, ctrl} == 5'b0, "R1 ctrl/mode/scan", W'({mode, scan, ctrl}), '0);
        chk({evt_done, evt_upd} == 2'b0, "R1 events", W'({evt_done, evt_upd}), '0);

        // R6 stop/update ignored while idle
        wr(0, 32'h6);
        chk(ctrl == 3'b000, "R6 idle stop/upd ignored", W'(ctrl), '0);

        // R2 bank writes do not reach active
        fill_bank();
        chk(active == '0, "R2 no commit on write", active, '0);

        // R3 run edge in video mode
        wr(0, 32'h1);
        exp_active = pack_bank();
        chk(active == exp_active, "R3 run latches bank", active, exp_active);
        chk(scan && ctrl == 3'b001, "R3 scanning with run", W'({scan, ctrl}), W'(4'b1001));

        // R11 mode write while running ignored
        wr(1, 32'h1);
        chk(mode == 1'b0, "R11 mode held", W'(mode), '0);

        // R2/R4 directed update
        fill_bank();
        chk(active == exp_active, "R2 pending held", active, exp_active);
        pulse_fe();
        chk(active == exp_active && !evt_upd, "R4 no request no commit", active, exp_active);
        wr(0, 32'h4);
        chk(ctrl == 3'b101, "R4 update bit set", W'(ctrl), W'(3'b101));
        idle(3);
        chk(active == exp_active, "R4 wait for boundary", active, exp_active);
        pulse_fe();
        exp_active = pack_bank();
        chk(active == exp_active, "R4 commit at boundary", active, exp_active);
        chk(evt_upd && ctrl == 3'b001, "R4 event and selfclear", W'({evt_upd, ctrl}), W'(4'b1001));
        idle(1);
        chk(!evt_upd, "R12 update pulse one cycle", W'(evt_upd), '0);

        // R4/R2 random rounds
        for (int r = 0; r < 24; r++) begin
            int nw;
            bit do_upd;
            nw = $urandom_range(0, NUM_CFG);
            for (int k = 0; k < nw; k++) wr_bank($urandom_range(0, NUM_CFG - 1), $urandom);
            do_upd = $urandom_range(0, 1);
            if (do_upd) wr(0, 32'h4);
            idle($urandom_range(0, 3));
            pulse_fe();
            if (do_upd) exp_active = pack_bank();
            chk(active == exp_active, "R4 random commit", active, exp_active);
            chk(evt_upd == do_upd, "R4 random event", W'(evt_upd), W'(do_upd));
        end

        // R5 stop at frame end
        wr(0, 32'h2);
        idle(3);
        chk(scan && ctrl == 3'b011, "R5 still scanning", W'({scan, ctrl}), W'(4'b1011));
        pulse_fe();
        chk(!scan && ctrl == 3'b000 && evt_done, "R5 stopped at boundary", W'({scan, ctrl, evt_done}), W'(5'b00001));
        idle(1);
        chk(!evt_done, "R12 done pulse one cycle", W'(evt_done), '0);

        // R7/R8 command mode, pad source
        wr(1, 32'h1);
        chk(mode == 1'b1, "R11 mode accepted when idle", W'(mode), W'(1));
        wr(2, (32'h1 << 8) | (32'h1 << 10));
        fill_bank();
        wr(0, 32'h1);
        exp_active = pack_bank();
        chk(active == exp_active && !scan && ctrl == 3'b001, "R7 armed after run edge", W'({scan, ctrl}), W'(4'b0001));
        pulse_int();
        chk(!scan, "R8 unselected te ignored", W'(scan), '0);
        pulse_pad();
        chk(scan, "R7 scan after te", W'(scan), W'(1));

        // R10 busy writes ignored
        fill_bank();
        wr(0, 32'h7);
        chk(ctrl == 3'b001 && active == exp_active, "R10 run/stop/upd ignored when busy", active, exp_active);

        // R9 frame end ends command frame
        pulse_fe();
        chk(!scan && ctrl == 3'b000 && evt_done, "R9 self stop", W'({scan, ctrl, evt_done}), W'(5'b00001));
        chk(active == exp_active, "R2 command no shadow commit", active, exp_active);

        // R8 te disabled: start immediately
        wr(2, 32'h0);
        wr(0, 32'h1);
        exp_active = pack_bank();
        chk(scan && active == exp_active, "R8 te off starts at run", active, exp_active);
        pulse_fe();
        chk(!scan && evt_done, "R9 second frame done", W'({scan, evt_done}), W'(2'b01));

        // R8 internal source
        wr(2, 32'h1 << 8);
        wr(0, 32'h1);
        pulse_pad();
        chk(!scan, "R8 pad ignored when internal selected", W'(scan), '0);
        pulse_int();
        chk(scan, "R8 internal te starts frame", W'(scan), W'(1));
        pulse_fe();
        chk(!scan && ctrl == 3'b000, "R9 third frame done", W'({scan, ctrl}), '0);

        idle(2);
        finish_run();
    end

endmodule